// File: doc/BRIEF.md
# Five-State JK Sequence Counter

This block is a 3-bit synchronous counter. It steps through a fixed cycle of five values that is not a binary order: 2, 3, 5, 1, 7, and then back to 2. Three JK flip-flop stages share one clock edge, so all bits change together. A small set of excitation terms derived from the present state drives the J and K input of each stage.

The three codes outside the cycle (0, 4 and 6) each have a defined next state that lies inside the cycle, so the counter cannot lock up. A synchronous reset loads a start value, set by a parameter that defaults to 2. A count enable freezes the counter by forcing every J and K to zero. The J and K values of each stage are brought out as ports so that the excitation can be observed.

Top module: `seq5_jk_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, `count` takes the value of parameter RESET_VALUE (default 2) on that edge. Reset takes priority over `en`.
- R2: With `en` high, each rising edge moves `count` one step along the cycle 2→3→5→1→7→2.
- R3: With `en` high, the codes outside the cycle recover in a single edge: 0 goes to 1, 4 goes to 5, and 6 goes to 7.
- R4: With `en` low, every bit of `stage_j` and `stage_k` is 0 and `count` does not change.
- R5: Bit i of `count` changes on each edge according to the JK rule applied to `stage_j[i]` and `stage_k[i]`. The pair {J,K} = 00 holds the bit, 01 clears it, 10 sets it and 11 inverts it.
- R6: From any starting code, `count` is one of 1, 2, 3, 5 or 7 after one enabled edge.
- R7: Once in the cycle, the value of `count` repeats every 5 enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all stages |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable, active high |
| count | output | 3 | Present state of the counter |
| stage_j | output | 3 | J input of each stage, bit i drives stage i |
| stage_k | output | 3 | K input of each stage, bit i drives stage i |

## Verification
The bench builds eight copies of the counter, one for each RESET_VALUE from 0 to 7. A single reset therefore places the counter in every one of the eight codes at once, including the three that no correct run can reach, and no load port is needed. An arithmetic model of the cycle and of the recovery steps gives the expected value of each copy on every edge. The bench also checks each copy's exposed J/K pairs against the JK rule, the period of 5, the freeze when the enable is low, and reset overriding a disabled enable.

// File: rtl/seq5_jk_counter.sv
module seq5_jk_counter #(
  parameter logic [2:0] RESET_VALUE = 3'd2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  output logic [2:0] count,
  output logic [2:0] stage_j,
  output logic [2:0] stage_k
);

  logic [2:0] q;
  logic [2:0] q_next;

  function automatic logic jk_step(input logic cur, input logic j, input logic k);
    case ({j, k})
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  assign stage_j = en ? {q[0], ~q[2] & q[0], 1'b1}       : 3'b000;
  assign stage_k = en ? {q[0], ~q[2] & q[0], q[2] & q[1]} : 3'b000;

  always_comb begin
    for (int i = 0; i < 3; i++) q_next[i] = jk_step(q[i], stage_j[i], stage_k[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VALUE;
    else     q <= q_next;
  end

  assign count = q;

  p_cycle_2_r2: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd2) |=> q == 3'd3);
  p_cycle_3_r2: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd3) |=> q == 3'd5);
  p_cycle_5_r2: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd5) |=> q == 3'd1);
  p_cycle_1_r2: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd1) |=> q == 3'd7);
  p_cycle_7_r2: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd7) |=> q == 3'd2);

  p_recover_0_r3: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd0) |=> q == 3'd1);
  p_recover_4_r3: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd4) |=> q == 3'd5);
  p_recover_6_r3: assert property (@(posedge clk) disable iff (rst) (en && q == 3'd6) |=> q == 3'd7);

  p_hold_r4: assert property (@(posedge clk) disable iff (rst) !en |=> $stable(q));

  p_legal_r6: assert property (@(posedge clk) disable iff (rst)
    en |=> (q == 3'd1 || q == 3'd2 || q == 3'd3 || q == 3'd5 || q == 3'd7));

  for (genvar g = 0; g < 3; g++) begin : g_stage_chk
    p_toggle_r5: assert property (@(posedge clk) disable iff (rst)
      (stage_j[g] && stage_k[g]) |=> q[g] != $past(q[g]));
    p_set_r5: assert property (@(posedge clk) disable iff (rst)
      (stage_j[g] && !stage_k[g]) |=> q[g]);
    p_clear_r5: assert property (@(posedge clk) disable iff (rst)
      (!stage_j[g] && stage_k[g]) |=> !q[g]);
  end

endmodule

// File: tb/seq5_jk_counter_bench.sv
module seq5_jk_counter_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic [2:0] cnt [8];
  logic [2:0] jv  [8];
  logic [2:0] kv  [8];

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  for (genvar g = 0; g < 8; g++) begin : g_dut
    seq5_jk_counter #(.RESET_VALUE(3'(g))) u_seq5_jk_counter (
      .clk(clk), .rst(rst), .en(en),
      .count(cnt[g]), .stage_j(jv[g]), .stage_k(kv[g])
    );
  end

  function automatic logic [2:0] model_next(input logic [2:0] s);
    int order [5] = '{2, 3, 5, 1, 7};
    for (int i = 0; i < 5; i++)
      if (int'(s) == order[i]) return 3'(order[(i + 1) % 5]);
    return s + 3'd1;
  endfunction

  function automatic bit is_legal(input logic [2:0] s);
    return s == 3'd1 || s == 3'd2 || s == 3'd3 || s == 3'd5 || s == 3'd7;
  endfunction

  function automatic logic jk_rule(input logic b, input logic j, input logic k);
    if (j && k) return ~b;
    if (j)      return 1'b1;
    if (k)      return 1'b0;
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    logic [2:0] prev [8];
    logic [2:0] ref1 [8];
    logic [2:0] ref6 [8];
    rst = 1'b1; en = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    for (int g = 0; g < 8; g++) check(cnt[g] == 3'(g), "R1 reset value", cnt[g], g);
    rst = 1'b0;

    for (int step = 0; step < 12; step++) begin
      for (int g = 0; g < 8; g++) begin
        prev[g] = cnt[g];
        for (int b = 0; b < 3; b++)
          check(jk_rule(prev[g][b], jv[g][b], kv[g][b]) == model_next(prev[g])[b],
                "R5 jk rule", int'(jk_rule(prev[g][b], jv[g][b], kv[g][b])),
                int'(model_next(prev[g])[b]));
      end
      @(posedge clk); @(negedge clk);
      for (int g = 0; g < 8; g++) begin
        if (is_legal(prev[g]))
          check(cnt[g] == model_next(prev[g]), "R2 cycle step", cnt[g], model_next(prev[g]));
        else
          check(cnt[g] == model_next(prev[g]), "R3 recovery", cnt[g], model_next(prev[g]));
        if (step == 0) begin
          check(is_legal(cnt[g]), "R6 in cycle after one edge", cnt[g], 2);
          ref1[g] = cnt[g];
        end
        if (step == 1) ref6[g] = cnt[g];
        if (step == 5) check(cnt[g] == ref1[g], "R7 period 5", cnt[g], ref1[g]);
        if (step == 6) check(cnt[g] == ref6[g], "R7 period 5", cnt[g], ref6[g]);
      end
    end

    en = 1'b0;
    #1;
    for (int g = 0; g < 8; g++) begin
      check(jv[g] == 3'b000, "R4 J zero", jv[g], 0);
      check(kv[g] == 3'b000, "R4 K zero", kv[g], 0);
      prev[g] = cnt[g];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < 8; g++) check(cnt[g] == prev[g], "R4 hold", cnt[g], prev[g]);

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    for (int g = 0; g < 8; g++) check(cnt[g] == 3'(g), "R1 reset over disabled", cnt[g], g);
    rst = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule